// File: doc/BRIEF.md
# Interrupt Gate Dispatch Sequencer

This block carries out the entry half of taking an interrupt through a gate table. Given an 8-bit vector and a 48-bit table register, it checks the gate's 8-byte slot against the table limit. It then reads the two 32-bit words of the gate over a request/ready read port and decodes them. A valid gate makes the block emit the handler frame as a run of stack writes. The block finishes with a one-cycle completion pulse and presents the handler's code selector, entry offset and updated flags.

The caller supplies the interrupted context: flags, code selector, instruction pointer, stack selector and stack pointer. It also supplies the current privilege, the privilege of the target code segment and the stack pointer of the inner ring. The gate type selects one of two frame item sizes, 16-bit or 32-bit. It also selects whether the interrupt-enable flag (bit 9 of the flags word) is cleared. A privilege change adds the old stack selector and stack pointer to the frame, and the frame is then built on the inner stack. A bad slot or a bad gate ends the sequence with a one-cycle fault pulse and no stack writes.

Top module: `intgate_dispatch`

## Requirements
- R1: The table base is `idt_reg[47:16]` and the limit is `idt_reg[15:0]`. The gate slot address is base + 8*vector. The low word is read at that address, then the high word at address+4. `rd_addr` stays stable while `rd_valid` is high and `rd_ready` is low.
- R2: If 8*vector+7 exceeds the limit, the block pulses `fault` for one cycle. It issues no read and no stack write.
- R3: The high word is decoded as follows: bit 15 present, bit 12 system flag, bits 11:8 type. A gate that is not present, that has bit 12 set, or whose type is not 0x6, 0x7, 0xE or 0xF pulses `fault` after both reads, with no stack write.
- R4: Types 0x6 and 0x7 push 16-bit items: `wr_wide`=0, the pointer steps by 2 and `wr_data[31:16]` is zero. Types 0xE and 0xF push 32-bit items: `wr_wide`=1 and the pointer steps by 4. Each write address is the pointer after it has been decremented.
- R5: With `cur_priv` equal to `tgt_priv`, exactly three writes occur, starting below `cur_sp`: flags, then code selector (zero-extended), then instruction pointer.
- R6: With `cur_priv` different from `tgt_priv`, two extra writes come first, starting below `inner_sp`: old stack selector, then old stack pointer.
- R7: Interrupt gates (0x6, 0xE) present `out_flags` equal to `cur_flags` with bit 9 cleared. Trap gates (0x7, 0xF) present `cur_flags` unchanged. The pushed flags item is always the unmodified `cur_flags`.
- R8: `done` is high for exactly the cycle after the last stack write. From then until the next accepted start, `out_cs` holds the gate selector (low word bits 31:16). Over the same span `out_ip` holds the entry offset: high-word bits 31:16 joined to low-word bits 15:0, with bits 31:16 zeroed for 16-bit gates.
- R9: `fault` and `done` are never high together. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a dispatch (accepted when idle) |
| vector | input | 8 | Interrupt vector |
| idt_reg | input | 48 | Table base (47:16) and limit (15:0) |
| cur_priv | input | 2 | Current privilege level |
| tgt_priv | input | 2 | Privilege of the handler code segment |
| cur_flags | input | 32 | Interrupted flags word |
| cur_cs | input | 16 | Interrupted code selector |
| cur_ip | input | 32 | Interrupted instruction pointer |
| cur_ss | input | 16 | Interrupted stack selector |
| cur_sp | input | 32 | Interrupted stack pointer |
| inner_sp | input | 32 | Stack pointer of the handler ring |
| rd_valid | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Read completes this cycle, data valid |
| rd_data | input | 32 | Read data |
| wr_en | output | 1 | Stack write strobe |
| wr_wide | output | 1 | 1: 32-bit item, 0: 16-bit item |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| out_cs | output | 16 | Handler code selector |
| out_ip | output | 32 | Handler entry offset |
| out_flags | output | 32 | Flags after entry |

## Verification
The assertions assume that the read port answers with `rd_ready` only while `rd_valid` is high, and for a single cycle per request. They also assume that a stack write sequence is never interrupted by reset. The bench's memory responder raises `rd_ready` for exactly one cycle after a latency of zero to two cycles, and only against a pending request. Reset is applied only before the first dispatch. The bench sweeps every vector of a 64-entry table: every type code, present and absent, and system flag set and clear. It also covers vectors past the limit, both privilege cases, and interrupt-enable set and clear.

// File: rtl/intgate_dispatch.sv
module intgate_dispatch #(
  parameter int IF_BIT = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  vector,
  input  logic [47:0] idt_reg,
  input  logic [1:0]  cur_priv,
  input  logic [1:0]  tgt_priv,
  input  logic [31:0] cur_flags,
  input  logic [15:0] cur_cs,
  input  logic [31:0] cur_ip,
  input  logic [15:0] cur_ss,
  input  logic [31:0] cur_sp,
  input  logic [31:0] inner_sp,
  output logic        rd_valid,
  output logic [31:0] rd_addr,
  input  logic        rd_ready,
  input  logic [31:0] rd_data,
  output logic        wr_en,
  output logic        wr_wide,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [15:0] out_cs,
  output logic [31:0] out_ip,
  output logic [31:0] out_flags
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RLO, ST_RHI, ST_DEC, ST_PUSH, ST_DONE, ST_FLT
  } state_t;

  state_t      st;
  logic [31:0] slot_r, lo_r, hi_r, flags_r, ip_r, sp_old_r, stk_r;
  logic [15:0] cs_r, ss_r;
  logic        chg_r, wide_r;
  logic [2:0]  idx_r;

  logic        in_limit, gate_ok;
  logic [3:0]  gtype;
  logic [31:0] item, step;

  assign in_limit = {5'd0, vector, 3'b111} <= idt_reg[15:0];
  assign gtype    = hi_r[11:8];
  assign gate_ok  = hi_r[15] && !hi_r[12] && (gtype[2:1] == 2'b11);
  assign step     = wide_r ? 32'd4 : 32'd2;

  always_comb begin
    case (idx_r)
      3'd0:    item = {16'd0, ss_r};
      3'd1:    item = sp_old_r;
      3'd2:    item = flags_r;
      3'd3:    item = {16'd0, cs_r};
      default: item = ip_r;
    endcase
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_DONE);
  assign fault    = (st == ST_FLT);
  assign rd_valid = (st == ST_RLO) || (st == ST_RHI);
  assign rd_addr  = (st == ST_RHI) ? slot_r + 32'd4 : slot_r;
  assign wr_en    = (st == ST_PUSH);
  assign wr_wide  = wide_r;
  assign wr_addr  = stk_r - step;
  assign wr_data  = wide_r ? item : {16'd0, item[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      slot_r    <= '0;
      lo_r      <= '0;
      hi_r      <= '0;
      flags_r   <= '0;
      ip_r      <= '0;
      sp_old_r  <= '0;
      stk_r     <= '0;
      cs_r      <= '0;
      ss_r      <= '0;
      chg_r     <= 1'b0;
      wide_r    <= 1'b0;
      idx_r     <= '0;
      out_cs    <= '0;
      out_ip    <= '0;
      out_flags <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          slot_r   <= idt_reg[47:16] + {21'd0, vector, 3'd0};
          flags_r  <= cur_flags;
          cs_r     <= cur_cs;
          ip_r     <= cur_ip;
          ss_r     <= cur_ss;
          sp_old_r <= cur_sp;
          chg_r    <= (cur_priv != tgt_priv);
          stk_r    <= (cur_priv != tgt_priv) ? inner_sp : cur_sp;
          st       <= in_limit ? ST_RLO : ST_FLT;
        end
        ST_RLO: if (rd_ready) begin
          lo_r <= rd_data;
          st   <= ST_RHI;
        end
        ST_RHI: if (rd_ready) begin
          hi_r <= rd_data;
          st   <= ST_DEC;
        end
        ST_DEC: begin
          if (gate_ok) begin
            wide_r    <= gtype[3];
            idx_r     <= chg_r ? 3'd0 : 3'd2;
            out_cs    <= lo_r[31:16];
            out_ip    <= {gtype[3] ? hi_r[31:16] : 16'd0, lo_r[15:0]};
            out_flags <= gtype[0] ? flags_r : (flags_r & ~(32'd1 << IF_BIT));
            st        <= ST_PUSH;
          end else begin
            st <= ST_FLT;
          end
        end
        ST_PUSH: begin
          stk_r <= wr_addr;
          idx_r <= idx_r + 3'd1;
          if (idx_r == 3'd4) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

module intgate_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        wr_en,
  input logic        wr_wide,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        done,
  input logic        fault
);

  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R2 and R3: a fault never follows a stack write
  assert_fault_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !$past(wr_en));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_wide == $past(wr_wide) &&
      wr_addr == $past(wr_addr) - (wr_wide ? 32'd4 : 32'd2));

  assert_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_wide |-> wr_data[31:16] == 16'd0);

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en) && !wr_en);

  assert_pulses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault) && !(rd_valid && wr_en));

endmodule

bind intgate_dispatch intgate_dispatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr),
  .wr_data(wr_data), .done(done), .fault(fault)
);

// File: tb/intgate_dispatch_tb.sv
module intgate_dispatch_tb;

  localparam logic [31:0] BASE = 32'h0002_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vector = '0;
  logic [47:0] idt_reg = '0;
  logic [1:0]  cur_priv = '0, tgt_priv = '0;
  logic [31:0] cur_flags = '0, cur_ip = '0, cur_sp = '0, inner_sp = '0;
  logic [15:0] cur_cs = '0, cur_ss = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        wr_en, wr_wide, busy, done, fault;
  logic [31:0] wr_addr, wr_data, out_ip, out_flags;
  logic [15:0] out_cs;

  int n_chk = 0, n_bad = 0;
  int lat = 0, wcnt = 0;
  int nw = 0, nr = 0;
  logic [31:0] wa [8];
  logic [31:0] wd [8];
  logic        ww [8];
  logic [31:0] ra [4];

  always #10 clk = ~clk;

  intgate_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .idt_reg(idt_reg),
    .cur_priv(cur_priv), .tgt_priv(tgt_priv), .cur_flags(cur_flags),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
    .inner_sp(inner_sp), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_en(wr_en), .wr_wide(wr_wide),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .fault(fault), .out_cs(out_cs), .out_ip(out_ip), .out_flags(out_flags)
  );

  // Table contents: type = v[3:0], present unless v[5:4]==3, system bit when v[5:4]==2
  function automatic logic [31:0] gate_lo(input int v);
    return {16'h0100 + 16'(v), 16'h1234 + 16'(v * 3)};
  endfunction
  function automatic logic [31:0] gate_hi(input int v);
    logic p, s;
    p = (v / 16) % 4 != 3;
    s = (v / 16) % 4 == 2;
    return {16'hC0DE ^ 16'(v), p, 2'(v % 4), s, 4'(v % 16), 8'h00};
  endfunction
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] off;
    off = a - BASE;
    return off[2] ? gate_hi(int'(off[31:3])) : gate_lo(int'(off[31:3]));
  endfunction

  initial forever begin
    @(negedge clk);
    if (rd_ready) rd_ready = 1'b0;
    else if (rd_valid) begin
      if (wcnt >= lat) begin
        rd_ready = 1'b1;
        rd_data  = mem_word(rd_addr);
        if (nr < 4) ra[nr] = rd_addr;
        nr++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  initial forever begin
    @(negedge clk);
    if (wr_en) begin
      if (nw < 8) begin
        wa[nw] = wr_addr; wd[nw] = wr_data; ww[nw] = wr_wide;
      end
      nw++;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input int v, input logic chg, input logic ifset,
                          input logic [15:0] lim, input logic dbl);
    logic [31:0] exp_d [5];
    logic [31:0] sp, stp, fl, item, slot;
    logic lim_f, dec_f, wide, trap;
    int ne, k;
    logic [3:0] ty;
    idt_reg   = {BASE, lim};
    vector    = 8'(v);
    cur_priv  = 2'd3;
    tgt_priv  = chg ? 2'd0 : 2'd3;
    cur_flags = 32'h0000_0002 | (32'(v) << 12) | (ifset ? 32'h200 : 32'h0);
    cur_cs    = 16'h0008 + 16'(v);
    cur_ip    = 32'h9876_5430 + 32'(v);
    cur_ss    = 16'h0010 + 16'(v);
    cur_sp    = 32'h0000_8000 + 32'(v * 16);
    inner_sp  = 32'h0003_0000 - 32'(v * 8);
    lat = v % 3; wcnt = 0; nw = 0; nr = 0;
    slot  = BASE + 32'(v * 8);
    lim_f = (v * 8 + 7) > int'(lim);
    ty    = 4'(v % 16);
    dec_f = !lim_f && (((v / 16) % 4 == 3) || ((v / 16) % 4 == 2) || ty[2:1] != 2'b11);
    wide  = ty[3];
    trap  = ty[0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = dbl;
    if (dbl) vector = ~8'(v);
    k = 0;
    while (!(done || fault) && k < 100) begin
      @(negedge clk); start = 1'b0; k++;
    end
    start = 1'b0;
    vector = 8'(v);
    if (lim_f) begin
      chk(fault && !done, $sformatf("R2 fault v=%0d", v), 32'(fault), 1);
      chk(nr == 0 && nw == 0, $sformatf("R2 no access v=%0d", v), 32'(nr + nw), 0);
    end else if (dec_f) begin
      chk(fault && !done, $sformatf("R3 fault v=%0d", v), 32'(fault), 1);
      chk(nw == 0, $sformatf("R3 no writes v=%0d", v), 32'(nw), 0);
      chk(nr == 2 && ra[0] == slot && ra[1] == slot + 4, $sformatf("R1 reads v=%0d", v), ra[1], slot + 4);
    end else begin
      chk(done && !fault, $sformatf("R9 done only v=%0d", v), {fault, done}, 1);
      chk(nr == 2 && ra[0] == slot, $sformatf("R1 low read v=%0d", v), ra[0], slot);
      chk(ra[1] == slot + 4, $sformatf("R1 high read v=%0d", v), ra[1], slot + 4);
      stp = wide ? 32'd4 : 32'd2;
      sp  = chg ? inner_sp : cur_sp;
      ne = 0;
      if (chg) begin
        exp_d[ne++] = {16'd0, cur_ss};
        exp_d[ne++] = cur_sp;
      end
      exp_d[ne++] = cur_flags;
      exp_d[ne++] = {16'd0, cur_cs};
      exp_d[ne++] = cur_ip;
      chk(nw == ne, chg ? "R6 write count" : "R5 write count", 32'(nw), 32'(ne));
      for (int i = 0; i < ne && i < nw; i++) begin
        sp = sp - stp;
        item = wide ? exp_d[i] : {16'd0, exp_d[i][15:0]};
        chk(wa[i] == sp, $sformatf("R4 addr v=%0d i=%0d", v, i), wa[i], sp);
        chk(wd[i] == item, $sformatf("%s data v=%0d i=%0d", chg ? "R6" : "R5", v, i), wd[i], item);
        chk(ww[i] == wide, $sformatf("R4 width v=%0d", v), 32'(ww[i]), 32'(wide));
      end
      fl = trap ? cur_flags : (cur_flags & ~32'h200);
      chk(out_flags == fl, $sformatf("R7 flags v=%0d", v), out_flags, fl);
      chk(out_cs == 16'h0100 + 16'(v), $sformatf("R8 cs v=%0d", v), 32'(out_cs), 32'(16'h0100 + 16'(v)));
      item = {wide ? (16'hC0DE ^ 16'(v)) : 16'd0, 16'h1234 + 16'(v * 3)};
      chk(out_ip == item, $sformatf("R8 ip v=%0d", v), out_ip, item);
      @(negedge clk);
      chk(!done && !busy, $sformatf("R8 done single v=%0d", v), {busy, done}, 0);
      @(negedge clk);
      chk(out_ip == item && out_cs == 16'h0100 + 16'(v), $sformatf("R8 hold v=%0d", v), out_ip, item);
      if (dbl) chk(nw == ne, $sformatf("R9 start ignored v=%0d", v), 32'(nw), 32'(ne));
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !wr_en && !rd_valid, "reset state", {busy, done, fault, wr_en, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 2; f++)
        for (int v = 0; v < 72; v++)
          run_case(v, c[0], f[0], 16'd511, (v % 5 == 0) && v < 64);
    run_case(6, 1'b0, 1'b1, 16'd54, 1'b0);   // R2 one byte short of the slot
    run_case(6, 1'b0, 1'b1, 16'd55, 1'b0);   // R2 slot exactly fits
    run_case(15, 1'b1, 1'b1, 16'd127, 1'b0);
    run_case(16, 1'b0, 1'b0, 16'd127, 1'b0); // R2 first vector past limit
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule